// File: doc/BRIEF.md
# Multiply-Add Request Sequencer

This block runs a control state machine that hands a multiply-add operation (`a*b + c`) to a separate pipelined arithmetic unit. The two sides talk only through a request/acknowledge pair. The state machine raises a request together with its operands. The unit raises an acknowledge whose meaning depends on the mode of that request. The unit's pipeline depth is a parameter. Neither the state machine nor the request/acknowledge interface changes when that depth changes, because the acknowledge comes from a chain of flops beside the datapath whose length follows the depth.

The block has two modes. In wait mode (`stream_en` low when `start` is taken), the state machine latches the operands, issues one request and then parks until the unit reports that the operation has finished. It then emits a one-cycle `done` pulse and returns to idle. In streaming mode (`stream_en` high), a request goes out in every cycle that `start` is high while the block is idle. For these requests the acknowledge only says that the operands were taken, and it is visible at once on `accept`. Each result comes back later, flagged by `res_valid`. A collector stage that runs apart from the issuing machine registers it.

Top module: `mac_sequencer`

## Requirements
- R1: During any cycle that follows a rising edge with `rst` high, `busy`, `done` and `res_valid` are 0. An operation that is in flight when reset is applied never produces `res_valid` after the reset.
- R2: Every result on `res_data` equals `(opnd_a * opnd_b + opnd_c) mod 2^(2*OPW)`. `opnd_a` and `opnd_b` are unsigned OPW-bit values and `opnd_c` is an unsigned 2*OPW-bit value.
- R3: In wait mode, `start` with `stream_en` = 0 taken while idle at rising edge k makes `done` and `res_valid` high together for exactly the one cycle after edge k+LATENCY+1, with the result on `res_data`.
- R4: For a wait-mode operation taken at edge k, `busy` is high in the cycles after edges k through k+LATENCY+1 and is low again after edge k+LATENCY+2.
- R5: While `busy` is high, `start` is ignored for either value of `stream_en`: `accept` stays 0 and no extra `done` or `res_valid` appears.
- R6: In streaming mode, `accept` is high in the same cycle as `start` with `stream_en` = 1 whenever the block is idle. An operation taken at edge k gives `res_valid` for the single cycle after edge k+LATENCY. One operation can be taken per cycle, and the results come back in issue order.
- R7: Streaming operations never raise `done` or `busy`.
- R8: R3 to R7 hold for any LATENCY of 1 or more with the same ports and state machine. LATENCY 1 registers only the operands. LATENCY 2 adds a registered multiply-add. LATENCY 3 or more uses separate multiply and sum stages followed by plain retiming stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation command |
| stream_en | input | 1 | Mode for this command: 1 streaming, 0 wait |
| opnd_a | input | OPW | Multiplicand |
| opnd_b | input | OPW | Multiplier |
| opnd_c | input | 2*OPW | Addend |
| accept | output | 1 | Streaming operands taken this cycle |
| busy | output | 1 | Wait-mode operation in progress |
| done | output | 1 | Wait-mode completion pulse |
| res_valid | output | 1 | Result present on res_data |
| res_data | output | 2*OPW | Multiply-add result |

## Verification
The assertions assume that `start` is synchronous to `clk` and that the operands are stable in any cycle in which `start` is high. They also assume that a wait-mode completion can only arrive while the machine is waiting, which holds because the machine never has more than one wait-mode request outstanding. The stimulus drives every input on the falling edge, holds `start` for whole cycles only, and issues wait-mode commands only from idle, except where it deliberately probes that commands given while busy are ignored. Two instances with latencies 3 and 1 share the same stimulus, so each timing check is made against both depths.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/mac_ack_delay.sv
// Valid/tag delay line that runs beside the arithmetic pipeline.
module mac_ack_delay #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  input  logic in_tag,
  output logic out_vld,
  output logic out_tag
);

  logic [STAGES-1:0] vld_q;
  logic [STAGES-1:0] tag_q;

  // Only the valid bits are reset, so no acknowledge can appear after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      vld_q[0] <= in_vld;
      for (int i = 1; i < STAGES; i++) begin
        vld_q[i] <= vld_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    tag_q[0] <= in_tag;
    for (int i = 1; i < STAGES; i++) begin
      tag_q[i] <= tag_q[i-1];
    end
  end

  assign out_vld = vld_q[STAGES-1];
  assign out_tag = tag_q[STAGES-1];

  AST_RESET_QUIET: assert property (@(posedge clk) $fell(rst) |-> !out_vld) else $error("valid survived reset"); // R1

endmodule

// File: rtl/mac_pipe_unit.sv
// Pipelined multiply-add with a request/acknowledge interface.
module mac_pipe_unit #(
  parameter int OPW = 8,
  parameter int LAT = 3,
  localparam int ACCW = 2 * OPW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            req_stream,
  input  logic [OPW-1:0]  a,
  input  logic [OPW-1:0]  b,
  input  logic [ACCW-1:0] c,
  output logic            ack_take,
  output logic            ack_done,
  output logic            out_vld,
  output logic [ACCW-1:0] out_val
);

  logic tail_tag;

  // The unit is always ready, so a streaming request is taken at once.
  assign ack_take = req & req_stream;

  mac_ack_delay #(.STAGES(LAT)) u_delay (
    .clk    (clk),
    .rst    (rst),
    .in_vld (req),
    .in_tag (req_stream),
    .out_vld(out_vld),
    .out_tag(tail_tag)
  );

  // Completion is signalled only for wait-mode requests.
  assign ack_done = out_vld & ~tail_tag;

  logic [OPW-1:0]  a1, b1;
  logic [ACCW-1:0] c1;

  always_ff @(posedge clk) begin
    a1 <= a;
    b1 <= b;
    c1 <= c;
  end

  generate
    if (LAT == 1) begin : g_lat1
      assign out_val = ACCW'(a1) * ACCW'(b1) + c1;
    end else if (LAT == 2) begin : g_lat2
      logic [ACCW-1:0] sum_q;
      always_ff @(posedge clk) begin
        sum_q <= ACCW'(a1) * ACCW'(b1) + c1;
      end
      assign out_val = sum_q;
    end else begin : g_lat3
      localparam int TAILN = LAT - 2;
      logic [ACCW-1:0] prod_q, add_q;
      logic [ACCW-1:0] tail_q [TAILN];
      always_ff @(posedge clk) begin
        prod_q    <= ACCW'(a1) * ACCW'(b1);
        add_q     <= c1;
        tail_q[0] <= prod_q + add_q;
      end
      for (genvar i = 1; i < TAILN; i++) begin : g_retime
        always_ff @(posedge clk) begin
          tail_q[i] <= tail_q[i-1];
        end
      end
      assign out_val = tail_q[TAILN-1];
    end
  endgenerate

endmodule

// File: rtl/mac_req_fsm.sv
// Issuing state machine: wait-mode handshake and streaming pass-through.
module mac_req_fsm
  import mac_seq_pkg::*;
#(
  parameter int OPW = 8,
  localparam int ACCW = 2 * OPW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            stream_en,
  input  logic [OPW-1:0]  in_a,
  input  logic [OPW-1:0]  in_b,
  input  logic [ACCW-1:0] in_c,
  input  logic            ack_done,
  output logic            req,
  output logic            req_stream,
  output logic [OPW-1:0]  req_a,
  output logic [OPW-1:0]  req_b,
  output logic [ACCW-1:0] req_c,
  output logic            busy,
  output logic            done
);

  seq_state_t state_q, state_d;
  logic [OPW-1:0]  a_q, b_q;
  logic [ACCW-1:0] c_q;
  logic            idle;

  assign idle = (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start && !stream_en) state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT:  if (ack_done) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // Wait-mode operands are held for the issue cycle.
  always_ff @(posedge clk) begin
    if (idle && start && !stream_en) begin
      a_q <= in_a;
      b_q <= in_b;
      c_q <= in_c;
    end
  end

  assign req        = (state_q == ST_ISSUE) | (idle & start & stream_en);
  assign req_stream = idle;
  assign req_a      = idle ? in_a : a_q;
  assign req_b      = idle ? in_b : b_q;
  assign req_c      = idle ? in_c : c_q;
  assign busy       = !idle;
  assign done       = (state_q == ST_DONE);

  AST_DONE_NEEDS_ACK:   assert property (@(posedge clk) disable iff (rst) (state_q == ST_DONE) |-> $past(ack_done)) else $error("done without ack"); // R3
  AST_ISSUE_THEN_WAIT:  assert property (@(posedge clk) disable iff (rst) (state_q == ST_ISSUE) |=> (state_q == ST_WAIT)) else $error("issue not followed by wait"); // R3
  AST_ACK_ONLY_WAITING: assert property (@(posedge clk) disable iff (rst) ack_done |-> (state_q == ST_WAIT)) else $error("stray completion"); // R5

endmodule

// File: rtl/mac_result_collect.sv
// Consumer stage that registers each result flagged by the unit.
module mac_result_collect #(
  parameter int ACCW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [ACCW-1:0] in_val,
  output logic            res_valid,
  output logic [ACCW-1:0] res_data
);

  always_ff @(posedge clk) begin
    if (rst) res_valid <= 1'b0;
    else     res_valid <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) res_data <= in_val;
  end

endmodule

// File: rtl/mac_sequencer.sv
module mac_sequencer #(
  parameter int OPW     = 8,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stream_en,
  input  logic [OPW-1:0]    opnd_a,
  input  logic [OPW-1:0]    opnd_b,
  input  logic [2*OPW-1:0]  opnd_c,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              res_valid,
  output logic [2*OPW-1:0]  res_data
);

  localparam int ACCW = 2 * OPW;

  logic            req, req_stream, ack_done, out_vld;
  logic [OPW-1:0]  req_a, req_b;
  logic [ACCW-1:0] req_c, out_val;

  mac_req_fsm #(.OPW(OPW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .stream_en (stream_en),
    .in_a      (opnd_a),
    .in_b      (opnd_b),
    .in_c      (opnd_c),
    .ack_done  (ack_done),
    .req       (req),
    .req_stream(req_stream),
    .req_a     (req_a),
    .req_b     (req_b),
    .req_c     (req_c),
    .busy      (busy),
    .done      (done)
  );

  mac_pipe_unit #(.OPW(OPW), .LAT(LATENCY)) u_unit (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .req_stream(req_stream),
    .a         (req_a),
    .b         (req_b),
    .c         (req_c),
    .ack_take  (accept),
    .ack_done  (ack_done),
    .out_vld   (out_vld),
    .out_val   (out_val)
  );

  mac_result_collect #(.ACCW(ACCW)) u_collect (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (out_vld),
    .in_val   (out_val),
    .res_valid(res_valid),
    .res_data (res_data)
  );

  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst) accept |-> !busy) else $error("accept while busy"); // R5
  AST_DONE_WITH_RESULT: assert property (@(posedge clk) disable iff (rst) done |-> res_valid) else $error("done without result"); // R3

endmodule

// File: tb/test_mac_sequencer.sv
module test_mac_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int OPW = 8;
  localparam int L3 = 3;
  localparam int L1 = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic stream_en = 1'b0;
  logic [OPW-1:0]   a = '0, b = '0;
  logic [2*OPW-1:0] c = '0;

  logic acc3, busy3, done3, rv3;
  logic acc1, busy1, done1, rv1;
  logic [2*OPW-1:0] rd3, rd1;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [OPW-1:0]   sa [8];
  logic [OPW-1:0]   sb [8];
  logic [2*OPW-1:0] sc [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_sequencer #(.OPW(OPW), .LATENCY(L3)) i_mac_sequencer (
    .clk(clk), .rst(rst), .start(start), .stream_en(stream_en),
    .opnd_a(a), .opnd_b(b), .opnd_c(c),
    .accept(acc3), .busy(busy3), .done(done3), .res_valid(rv3), .res_data(rd3)
  );

  mac_sequencer #(.OPW(OPW), .LATENCY(L1)) i_mac_sequencer_lat1 (
    .clk(clk), .rst(rst), .start(start), .stream_en(stream_en),
    .opnd_a(a), .opnd_b(b), .opnd_c(c),
    .accept(acc1), .busy(busy1), .done(done1), .res_valid(rv1), .res_data(rd1)
  );

  function automatic logic [2*OPW-1:0] mac_ref(input logic [OPW-1:0] x, input logic [OPW-1:0] y,
                                               input logic [2*OPW-1:0] z);
    logic [2*OPW-1:0] xx, yy;
    xx = {{OPW{1'b0}}, x};
    yy = {{OPW{1'b0}}, y};
    return xx * yy + z;
  endfunction

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // R1: reset state, also used to abort an operation in flight
  task automatic t_reset(input bit with_inflight);
    @(negedge clk);
    if (with_inflight) begin
      start = 1'b1; stream_en = 1'b1; a = 8'd9; b = 8'd9; c = 16'd1;
      @(negedge clk);
      start = 1'b0;
    end
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "busy3 in reset", busy3, 0);
    check("R1", "rv3 in reset", rv3, 0);
    check("R1", "done1 in reset", done1, 0);
    rst = 1'b0;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      check("R1", "rv3 after reset", rv3, 0);
      check("R1", "rv1 after reset", rv1, 0);
      check("R1", "done3 after reset", done3, 0);
      check("R1", "busy1 after reset", busy1, 0);
    end
  endtask

  // R2 R3 R4 R5 R8: one wait-mode operation, optionally with ignored commands
  task automatic t_wait_op(input logic [OPW-1:0] x, input logic [OPW-1:0] y,
                           input logic [2*OPW-1:0] z, input bit inject);
    logic [2*OPW-1:0] exp;
    exp = mac_ref(x, y, z);
    @(negedge clk);
    start = 1'b1; stream_en = 1'b0; a = x; b = y; c = z;
    for (int n = 1; n <= L3 + 5; n++) begin
      @(negedge clk);
      start = 1'b0;
      a = ~x; b = ~y; c = ~z;
      check("R3", "done3 timing", done3, (n == L3 + 2));
      check("R3", "rv3 timing", rv3, (n == L3 + 2));
      check("R8", "done1 timing", done1, (n == L1 + 2));
      check("R8", "rv1 timing", rv1, (n == L1 + 2));
      check("R4", "busy3 window", busy3, (n <= L3 + 2));
      check("R4", "busy1 window", busy1, (n <= L1 + 2));
      if (n == L3 + 2) check("R2", "rd3 value", rd3, exp);
      if (n == L1 + 2) check("R2", "rd1 value", rd1, exp);
      if (inject && (n == 1 || n == 2)) begin
        start = 1'b1; stream_en = (n == 1);
        #1;
        check("R5", "acc3 while busy", acc3, 0);
        check("R5", "acc1 while busy", acc1, 0);
      end
    end
    start = 1'b0;
  endtask

  // R6 R7 R8: back-to-back streaming operations from sa/sb/sc
  task automatic t_stream(input int k);
    @(negedge clk);
    start = 1'b1; stream_en = 1'b1; a = sa[0]; b = sb[0]; c = sc[0];
    #1;
    check("R6", "acc3 first", acc3, 1);
    check("R6", "acc1 first", acc1, 1);
    for (int m = 1; m <= k + L3 + 2; m++) begin
      int i3, i1;
      @(negedge clk);
      i3 = m - 1 - L3;
      i1 = m - 1 - L1;
      check("R6", "rv3 stream", rv3, (i3 >= 0 && i3 < k));
      check("R8", "rv1 stream", rv1, (i1 >= 0 && i1 < k));
      if (i3 >= 0 && i3 < k) check("R6", "rd3 order", rd3, mac_ref(sa[i3], sb[i3], sc[i3]));
      if (i1 >= 0 && i1 < k) check("R6", "rd1 order", rd1, mac_ref(sa[i1], sb[i1], sc[i1]));
      check("R7", "done3 stream", done3, 0);
      check("R7", "busy1 stream", busy1, 0);
      if (m < k) begin
        a = sa[m]; b = sb[m]; c = sc[m];
        #1;
        check("R6", "acc3 each cycle", acc3, 1);
        check("R6", "acc1 each cycle", acc1, 1);
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy3 at reset", busy3, 0);
    check("R1", "done3 at reset", done3, 0);
    check("R1", "rv1 at reset", rv1, 0);
    rst = 1'b0;
    @(negedge clk);

    t_wait_op(8'd3, 8'd5, 16'd100, 1'b0);
    t_wait_op(8'd255, 8'd255, 16'hFFFF, 1'b0);
    t_wait_op(8'd0, 8'd77, 16'h1234, 1'b1);
    t_wait_op(8'd128, 8'd2, 16'h0001, 1'b1);

    for (int i = 0; i < 8; i++) begin
      sa[i] = 8'(i * 37 + 11);
      sb[i] = 8'(255 - i * 19);
      sc[i] = 16'(i * 4099 + 7);
    end
    t_stream(8);
    t_stream(1);

    t_wait_op(8'd17, 8'd19, 16'hF000, 1'b0);
    t_reset(1'b1);
    t_wait_op(8'd200, 8'd100, 16'd5, 1'b0);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule